// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block holds three management registers of an Ethernet PHY: a cable-diagnostic control and status word, a reset control word and a transmit-clock phase word. A management agent reaches them through a plain port made of an address, a write strobe and write data. Read data follows the address combinationally. The bank drives control lines into the rest of the PHY: a diagnostic launch level, a full-reset pulse, a datapath-restart pulse, and a phase value with a one-cycle apply pulse. It reads back the diagnostic completion and failure flags, the link-quality grade and the link-up status.

Several bits clear themselves. The diagnostic launch bit drops when the completion flag rises. Each of the reset, restart and phase-apply bits produces a single-cycle pulse. A soft reset returns every register to its default value. A restart leaves the register contents untouched. Phase codes that lie above the supported ceiling are folded back into range before they are stored.

Top module: `phyMgmtRegs`

## Requirements
- R1: After hardware reset, all control outputs are 0. Reads of addresses 0x1E, 0x1F and 0x42 return 0x0000 while all status inputs are 0.
- R2: A write to 0x1E sets the launch bit (bit 15, driven on diagStartOut) to the value of write bit 15, taking effect on the next clock edge. The bit reads back at bit 15.
- R3: On the clock edge where diagDoneIn is first seen high after being low, the launch bit is cleared. This clear takes priority over a write of 1 on that same edge. A done level that stays high does not block a later write of 1.
- R4: At address 0x1E, bit 1 reads diagDoneIn and bit 0 reads diagFailIn. Bits 15 and 9:8 are the only other bits that can be nonzero.
- R5: At address 0x1E, bits 9:8 read linkQualIn while linkUpIn is 1, and read 00 while linkUpIn is 0. The codes are 01 good, 10 mid, 11 poor and 00 reserved.
- R6: Writing 1 to bit 15 of 0x1F raises fullResetOut for exactly one cycle, starting after the next edge. During that cycle bit 15 reads 1. On the following edge every register returns to its default value.
- R7: Writing 1 to bit 14 of 0x1F raises dpRestartOut for exactly one cycle. During that cycle bit 14 reads 1. The launch bit and the phase value keep their contents.
- R8: A write to 0x42 takes the phase code v from write bits 12:8. It stores v when v is at most 10, and v mod 10 otherwise. The stored value drives phaseValOut and reads back at bits 12:8.
- R9: Writing 1 to bit 0 of 0x42 raises phaseApplyOut for exactly one cycle, during which bit 0 reads 1. The stored phase value is not changed when the pulse ends.
- R10: Reserved bits ignore writes and read 0. Any other address reads 0x0000, and writes to it change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrStb | input | 1 | Write strobe, one write per cycle when high |
| regAddr | input | 8 | Register address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for regAddr |
| diagDoneIn | input | 1 | Cable measurement finished |
| diagFailIn | input | 1 | Cable measurement failed |
| linkQualIn | input | 2 | Link quality grade |
| linkUpIn | input | 1 | Link is up |
| diagStartOut | output | 1 | Launch level for the cable measurement |
| fullResetOut | output | 1 | One-cycle full PHY reset request |
| dpRestartOut | output | 1 | One-cycle datapath restart request |
| phaseValOut | output | 4 | Stored transmit-clock phase step |
| phaseApplyOut | output | 1 | One-cycle request to apply the phase |

## Verification
The bench builds the bank with its default parameters: an 8-bit address, a 5-bit phase field and a phase ceiling of 10. With an 8-bit address, every one of the 256 addresses can be written and read back, so decoding of unmapped locations is checked completely. With a 5-bit field, all 32 phase codes are folded and compared with the arithmetic expectation, including the boundary at 10 and the largest codes. Every combination of link status, quality grade and failure flag is also read through the diagnostic word.

// File: rtl/phyMgmtPkg.sv
package phyMgmtPkg;

  // Write strobes and event flags passed from control to datapath
  typedef struct packed {
    logic diagWr;
    logic rstWr;
    logic phaseWr;
    logic doneRise;
  } regStrobe_t;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_DIAG  = 2'd1,
    SEL_RST   = 2'd2,
    SEL_PHASE = 2'd3
  } rdSel_t;

endpackage

// File: rtl/phyMgmtCtrl.sv
module phyMgmtCtrl
  import phyMgmtPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DIAG_ADDR  = 'h1E,
  parameter int RST_ADDR   = 'h1F,
  parameter int PHASE_ADDR = 'h42
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              diagDoneIn,
  output regStrobe_t        stb,
  output rdSel_t            rdSel
);

  localparam logic [ADDR_W-1:0] DiagA  = ADDR_W'(DIAG_ADDR);
  localparam logic [ADDR_W-1:0] RstA   = ADDR_W'(RST_ADDR);
  localparam logic [ADDR_W-1:0] PhaseA = ADDR_W'(PHASE_ADDR);

  logic doneQ;

  // Sample the done flag to find its rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= diagDoneIn;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (regAddr == DiagA)       rdSel = SEL_DIAG;
    else if (regAddr == RstA)   rdSel = SEL_RST;
    else if (regAddr == PhaseA) rdSel = SEL_PHASE;
  end

  always_comb begin
    stb.diagWr   = wrStb && (rdSel == SEL_DIAG);
    stb.rstWr    = wrStb && (rdSel == SEL_RST);
    stb.phaseWr  = wrStb && (rdSel == SEL_PHASE);
    stb.doneRise = diagDoneIn && !doneQ;
  end

endmodule

// File: rtl/phyMgmtData.sv
module phyMgmtData
  import phyMgmtPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PHASE_MAX   = 10,
  parameter int PHASE_FLD_W = 5,
  parameter int PHASE_LSB   = 8,
  localparam int PHASE_W    = $clog2(PHASE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              diagDoneIn,
  input  logic              diagFailIn,
  input  logic [1:0]        linkQualIn,
  input  logic              linkUpIn,
  output logic [DATA_W-1:0] rdData,
  output logic              diagStartOut,
  output logic              fullResetOut,
  output logic              dpRestartOut,
  output logic [PHASE_W-1:0] phaseValOut,
  output logic              phaseApplyOut
);

  // Bit positions inside the words; the neighbouring logic decodes these
  localparam int StartBit   = 15;
  localparam int SwRstBit   = 15;
  localparam int RestartBit = 14;
  localparam int ApplyBit   = 0;
  localparam int QualLsb    = 8;
  localparam int DoneBit    = 1;
  localparam int FailBit    = 0;

  logic               startQ;
  logic               swRstQ;
  logic               restartQ;
  logic               applyQ;
  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_FLD_W-1:0] phaseIn;

  assign phaseIn = wrData[PHASE_LSB +: PHASE_FLD_W];

  // Fold an out-of-range phase code back into 0..PHASE_MAX
  function automatic logic [PHASE_W-1:0] foldPhase(input logic [PHASE_FLD_W-1:0] v);
    logic [PHASE_FLD_W-1:0] r;
    if (v > PHASE_FLD_W'(PHASE_MAX)) r = v % PHASE_FLD_W'(PHASE_MAX);
    else                             r = v;
    return PHASE_W'(r);
  endfunction

  // Diagnostic launch bit: soft reset, then done edge, then write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             startQ <= 1'b0;
    else if (swRstQ)       startQ <= 1'b0;
    else if (stb.doneRise) startQ <= 1'b0;
    else if (stb.diagWr)   startQ <= wrData[StartBit];
  end

  // Self-clearing reset request lasts one cycle per write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swRstQ <= 1'b0;
    else       swRstQ <= stb.rstWr && wrData[SwRstBit];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       restartQ <= 1'b0;
    else if (swRstQ) restartQ <= 1'b0;
    else             restartQ <= stb.rstWr && wrData[RestartBit];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       applyQ <= 1'b0;
    else if (swRstQ) applyQ <= 1'b0;
    else             applyQ <= stb.phaseWr && wrData[ApplyBit];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseQ <= '0;
    else if (swRstQ)      phaseQ <= '0;
    else if (stb.phaseWr) phaseQ <= foldPhase(phaseIn);
  end

  // Read assembly; reserved positions stay zero
  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_DIAG: begin
        rdData[StartBit]         = startQ;
        rdData[QualLsb +: 2]     = linkUpIn ? linkQualIn : 2'b00;
        rdData[DoneBit]          = diagDoneIn;
        rdData[FailBit]          = diagFailIn;
      end
      SEL_RST: begin
        rdData[SwRstBit]   = swRstQ;
        rdData[RestartBit] = restartQ;
      end
      SEL_PHASE: begin
        rdData[PHASE_LSB +: PHASE_W] = phaseQ;
        rdData[ApplyBit]             = applyQ;
      end
      default: rdData = '0;
    endcase
  end

  assign diagStartOut  = startQ;
  assign fullResetOut  = swRstQ;
  assign dpRestartOut  = restartQ;
  assign phaseValOut   = phaseQ;
  assign phaseApplyOut = applyQ;

endmodule

// File: rtl/phyMgmtRegs.sv
module phyMgmtRegs
  import phyMgmtPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int DIAG_ADDR   = 'h1E,
  parameter int RST_ADDR    = 'h1F,
  parameter int PHASE_ADDR  = 'h42,
  parameter int PHASE_MAX   = 10,
  parameter int PHASE_FLD_W = 5,
  parameter int PHASE_LSB   = 8,
  localparam int PHASE_W    = $clog2(PHASE_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrStb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               diagDoneIn,
  input  logic               diagFailIn,
  input  logic [1:0]         linkQualIn,
  input  logic               linkUpIn,
  output logic               diagStartOut,
  output logic               fullResetOut,
  output logic               dpRestartOut,
  output logic [PHASE_W-1:0] phaseValOut,
  output logic               phaseApplyOut
);

  regStrobe_t stb;
  rdSel_t     rdSel;

  phyMgmtCtrl #(
    .ADDR_W(ADDR_W), .DIAG_ADDR(DIAG_ADDR),
    .RST_ADDR(RST_ADDR), .PHASE_ADDR(PHASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .regAddr(regAddr),
    .diagDoneIn(diagDoneIn), .stb(stb), .rdSel(rdSel)
  );

  phyMgmtData #(
    .DATA_W(DATA_W), .PHASE_MAX(PHASE_MAX),
    .PHASE_FLD_W(PHASE_FLD_W), .PHASE_LSB(PHASE_LSB)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(wrData),
    .diagDoneIn(diagDoneIn), .diagFailIn(diagFailIn),
    .linkQualIn(linkQualIn), .linkUpIn(linkUpIn), .rdData(rdData),
    .diagStartOut(diagStartOut), .fullResetOut(fullResetOut),
    .dpRestartOut(dpRestartOut), .phaseValOut(phaseValOut),
    .phaseApplyOut(phaseApplyOut)
  );

endmodule

// File: rtl/phyMgmtChk.sv
module phyMgmtChk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int DIAG_ADDR  = 'h1E,
  parameter int RST_ADDR   = 'h1F,
  parameter int PHASE_ADDR = 'h42,
  parameter int PHASE_MAX  = 10,
  parameter int PHASE_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrStb,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic               diagDoneIn,
  input logic               linkUpIn,
  input logic               diagStartOut,
  input logic               fullResetOut,
  input logic               dpRestartOut,
  input logic [PHASE_W-1:0] phaseValOut,
  input logic               phaseApplyOut
);

  logic wrDiag, wrRst, wrPhase;
  assign wrDiag  = wrStb && (regAddr == ADDR_W'(DIAG_ADDR));
  assign wrRst   = wrStb && (regAddr == ADDR_W'(RST_ADDR));
  assign wrPhase = wrStb && (regAddr == ADDR_W'(PHASE_ADDR));

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(diagDoneIn) |=> !diagStartOut);

  // R2
  start_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrDiag && wrData[15] && !$rose(diagDoneIn) && !fullResetOut) |=> diagStartOut);

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullResetOut && !(wrRst && wrData[15])) |=> !fullResetOut);

  // R6
  rst_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullResetOut |=> (phaseValOut == '0 && !diagStartOut && !phaseApplyOut));

  // R7
  restart_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpRestartOut && !fullResetOut && !wrStb) |=> ($stable(phaseValOut) && $stable(diagStartOut)));

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseValOut <= PHASE_W'(PHASE_MAX));

  // R9
  apply_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseApplyOut && !wrPhase) |=> !phaseApplyOut);

  // R5
  qual_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!linkUpIn && regAddr == ADDR_W'(DIAG_ADDR)) |-> (rdData[9:8] == 2'b00));

endmodule

bind phyMgmtRegs phyMgmtChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIAG_ADDR(DIAG_ADDR),
  .RST_ADDR(RST_ADDR), .PHASE_ADDR(PHASE_ADDR),
  .PHASE_MAX(PHASE_MAX), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .regAddr(regAddr),
  .wrData(wrData), .rdData(rdData), .diagDoneIn(diagDoneIn),
  .linkUpIn(linkUpIn), .diagStartOut(diagStartOut),
  .fullResetOut(fullResetOut), .dpRestartOut(dpRestartOut),
  .phaseValOut(phaseValOut), .phaseApplyOut(phaseApplyOut)
);

// File: tb/test_phyMgmtRegs.sv
module test_phyMgmtRegs;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] DIAG  = 8'h1E;
  localparam logic [7:0] RSTR  = 8'h1F;
  localparam logic [7:0] PHASE = 8'h42;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        diagDoneIn = 1'b0;
  logic        diagFailIn = 1'b0;
  logic [1:0]  linkQualIn = 2'b00;
  logic        linkUpIn = 1'b0;
  logic        diagStartOut, fullResetOut, dpRestartOut, phaseApplyOut;
  logic [3:0]  phaseValOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phyMgmtRegs i_phyMgmtRegs (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .diagDoneIn(diagDoneIn),
    .diagFailIn(diagFailIn), .linkQualIn(linkQualIn), .linkUpIn(linkUpIn),
    .diagStartOut(diagStartOut), .fullResetOut(fullResetOut),
    .dpRestartOut(dpRestartOut), .phaseValOut(phaseValOut),
    .phaseApplyOut(phaseApplyOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 start", diagStartOut, 0);
    chk("R1 reset", fullResetOut, 0);
    chk("R1 restart", dpRestartOut, 0);
    chk("R1 phase", phaseValOut, 0);
    chk("R1 apply", phaseApplyOut, 0);
    readReg(DIAG, r);  chk("R1 diag read", r, 0);
    readReg(RSTR, r);  chk("R1 rst read", r, 0);
    readReg(PHASE, r); chk("R1 phase read", r, 0);

    // R4 / R5: all status combinations
    for (int i = 0; i < 16; i++) begin
      logic [15:0] e;
      linkUpIn = i[0]; linkQualIn = i[2:1]; diagFailIn = i[3];
      e = 16'(i[3]);
      if (i[0]) e = e | (16'(i[2:1]) << 8);
      readReg(DIAG, r);
      chk("R5 R4 status", r, e);
    end
    diagFailIn = 1'b0; linkUpIn = 1'b0; linkQualIn = 2'b00;
    @(negedge clk);
    diagDoneIn = 1'b1;
    readReg(DIAG, r); chk("R4 done bit", r, 16'h0002);
    @(negedge clk);
    diagDoneIn = 1'b0;
    @(negedge clk);

    // R2 launch bit write
    writeReg(DIAG, 16'hFFFF);
    chk("R2 start set", diagStartOut, 1);
    readReg(DIAG, r); chk("R2 R10 read", r, 16'h8000);
    writeReg(DIAG, 16'h0000);
    chk("R2 start cleared by write", diagStartOut, 0);

    // R3 clear on done rise
    writeReg(DIAG, 16'h8000);
    diagDoneIn = 1'b1;
    @(negedge clk);
    chk("R3 clear on rise", diagStartOut, 0);
    writeReg(DIAG, 16'h8000);
    chk("R3 held done no clear", diagStartOut, 1);
    @(negedge clk);
    chk("R3 held done stays", diagStartOut, 1);
    diagDoneIn = 1'b0;
    @(negedge clk);
    writeReg(DIAG, 16'h0000);
    @(negedge clk);
    regAddr = DIAG; wrData = 16'h8000; wrStb = 1'b1; diagDoneIn = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; wrData = '0;
    chk("R3 rise beats write", diagStartOut, 0);
    diagDoneIn = 1'b0;
    @(negedge clk);

    // R8 / R9: every phase code
    for (int v = 0; v < 32; v++) begin
      int e;
      e = (v > 10) ? (v % 10) : v;
      writeReg(PHASE, 16'((v << 8) | 1));
      chk("R8 phase fold", phaseValOut, e);
      chk("R9 apply pulse", phaseApplyOut, 1);
      readReg(PHASE, r); chk("R8 R9 read", r, 16'((e << 8) | 1));
      @(negedge clk);
      chk("R9 apply ends", phaseApplyOut, 0);
      readReg(PHASE, r); chk("R9 value kept", r, 16'(e << 8));
    end

    // R7 restart keeps registers
    writeReg(PHASE, 16'h0700);
    writeReg(DIAG, 16'h8000);
    writeReg(RSTR, 16'h4000);
    chk("R7 restart pulse", dpRestartOut, 1);
    chk("R7 no full reset", fullResetOut, 0);
    readReg(RSTR, r); chk("R7 read", r, 16'h4000);
    @(negedge clk);
    chk("R7 pulse ends", dpRestartOut, 0);
    chk("R7 phase kept", phaseValOut, 7);
    chk("R7 start kept", diagStartOut, 1);
    readReg(RSTR, r); chk("R7 read after", r, 0);

    // R10: reserved bits of reset word
    writeReg(RSTR, 16'h3FFF);
    chk("R10 no reset", fullResetOut, 0);
    chk("R10 no restart", dpRestartOut, 0);
    readReg(RSTR, r); chk("R10 rst reserved", r, 0);

    // R6 soft reset
    writeReg(RSTR, 16'h8000);
    chk("R6 reset pulse", fullResetOut, 1);
    readReg(RSTR, r); chk("R6 read", r, 16'h8000);
    @(negedge clk);
    chk("R6 pulse ends", fullResetOut, 0);
    chk("R6 phase default", phaseValOut, 0);
    chk("R6 start default", diagStartOut, 0);
    readReg(RSTR, r); chk("R6 read after", r, 0);

    // R10: unmapped addresses
    writeReg(PHASE, 16'h0300);
    writeReg(DIAG, 16'h8000);
    for (int a = 0; a < 256; a++) begin
      if (a == DIAG || a == RSTR || a == PHASE) continue;
      writeReg(8'(a), 16'hFFFF);
      readReg(8'(a), r);
      chk("R10 unmapped read", r, 0);
    end
    chk("R10 phase untouched", phaseValOut, 3);
    chk("R10 start untouched", diagStartOut, 1);
    chk("R10 no pulses", {fullResetOut, dpRestartOut, phaseApplyOut}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule